// File: doc/BRIEF.md
# Interleaved SECDED Burst-Error Link

This block protects blocks of 8-bit data words crossing a serial line that suffers bursts of bit errors. The transmit half takes words on a parallel input, encodes each one into a 13-bit extended Hamming codeword and collects a whole block of `N_WORDS` codewords. Once the block is full it sends the block as a bit stream ordered by bit plane: one bit position of every codeword, then the next position of every codeword. Because of this order, any run of up to `N_WORDS` consecutive damaged line bits touches each codeword at most once.

The receive half collects the incoming bit stream back into codewords. When a block is complete, it moves the block into a holding store and decodes one word per cycle. For each word it returns the corrected data, a flag saying a single error was repaired, and a flag saying a double error was detected, in the order the words were loaded. The transmit and receive stores are separate, and the receive side keeps a collection store and a holding store apart. A new block can therefore arrive while the previous one is still being decoded out.

Top module: `burst_guard_link`

## Requirements
- R1: Each word d[7:0] becomes a 13-bit codeword c[12:0]. Data bits d0..d7 sit at positions 3,5,6,7,9,10,11,12. The check bit at position 2^k (1,2,4,8) makes the XOR over all positions 1..12 whose index has bit k set equal to zero. Position 0 makes the XOR of all 13 bits equal to zero.
- R2: A word is taken on each clock edge where `wordValid` is high and `busy` is low. `busy` goes high in the cycle after the edge that takes the `N_WORDS`-th word. `wordValid` has no effect while `busy` is high.
- R3: After `busy` rises, `serValid` goes high one cycle later and stays high for 13·`N_WORDS` cycles. Line bit k carries bit position k / `N_WORDS` of codeword k mod `N_WORDS`. `busy` falls in the cycle that presents the last bit.
- R4: The receiver places the bit sampled on each edge with `rxValid` high in the same plane order. Cycles with `rxValid` low do not advance the placement.
- R5: The edge that samples a block's final bit is followed by `outValid` going high on the second edge after it. `outValid` then stays high for `N_WORDS` cycles, one word per cycle, in word order 0 to `N_WORDS`-1.
- R6: An undamaged codeword yields its data with both `outCorrected` and `outDouble` low.
- R7: A codeword with exactly one flipped bit, at any of the 13 positions including position 0, yields the original data with `outCorrected` high and `outDouble` low.
- R8: A codeword with exactly two flipped bits yields `outDouble` high and `outCorrected` low.
- R9: In loopback, a burst of up to `N_WORDS` consecutive flipped line bits yields the original data for every word of the block.
- R10: A new block may begin arriving in the cycle right after the previous block's last bit, while that block is being decoded out. Both blocks decode correctly.
- R11: While reset is asserted, `busy`, `serValid` and `outValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| wordValid | input | 1 | Offers `wordData` for loading |
| wordData | input | 8 | Data word to protect |
| busy | output | 1 | Transmit block is being sent; loading is refused |
| serBit | output | 1 | Serial line bit out |
| serValid | output | 1 | `serBit` carries a line bit this cycle |
| rxValid | input | 1 | `rxBit` carries a line bit this cycle |
| rxBit | input | 1 | Serial line bit in |
| outValid | output | 1 | A decoded word is presented |
| outData | output | 8 | Decoded (corrected where possible) data |
| outCorrected | output | 1 | A single error was repaired in this word |
| outDouble | output | 1 | A double error was detected in this word |

## Verification
Two receive-side actions can land in the same cycle. The first bit of a new block can be written into the collection store in the same cycle that the finished block is copied into the holding store. The first words of that finished block can also be decoded out while the new block keeps arriving. The bench provokes this by driving two receive blocks with no idle cycle between them, each block carrying single errors at varied positions. A scoreboard then requires every word of both blocks to come out with the right data and flags, in loading order.

// File: rtl/burst_guard_pkg.sv
package burst_guard_pkg;

  localparam int DATA_W  = 8;
  localparam int CHECK_W = 4;
  localparam int CODE_W  = DATA_W + CHECK_W + 1;
  localparam int POS_W   = $clog2(CODE_W);

  typedef logic [CODE_W-1:0] codeT;
  typedef logic [DATA_W-1:0] dataT;

  typedef struct packed {
    dataT data;
    logic corrected;
    logic dbl;
  } decodeT;

  // strobes from control to datapath
  typedef struct packed {
    logic txWrite;   // store an encoded word in the transmit store
    logic txSend;    // present one line bit from the transmit store
    logic rxWrite;   // place one received bit in the collection store
    logic rxCopy;    // move the collection store to the holding store
    logic rxEmit;    // decode one held word onto the outputs
  } strobeT;

  function automatic logic isCheckPos(int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic codeT encodeWord(dataT d);
    codeT c;
    int   k;
    logic par;
    c = '0;
    k = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if (!isCheckPos(p)) begin
        c[p] = d[k];
        k++;
      end
    end
    for (int b = 0; b < CHECK_W; b++) begin
      par = 1'b0;
      for (int p = 1; p < CODE_W; p++) begin
        if (p[b]) par = par ^ c[p];
      end
      c[1 << b] = par;
    end
    c[0] = ^c[CODE_W-1:1];
    return c;
  endfunction

  function automatic decodeT decodeWord(codeT c);
    logic [POS_W-1:0] syn;
    logic             total;
    logic             inRange;
    codeT             fixed;
    decodeT           r;
    int               k;
    syn = '0;
    for (int p = 1; p < CODE_W; p++) begin
      if (c[p]) syn = syn ^ p[POS_W-1:0];
    end
    total   = ^c;
    inRange = (int'(syn) < CODE_W);
    fixed   = c;
    if (total && (syn != '0) && inRange) fixed[syn] = ~fixed[syn];
    r.corrected = total && inRange;
    r.dbl       = (!total && (syn != '0)) || (total && !inRange);
    r.data      = '0;
    k = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if (!isCheckPos(p)) begin
        r.data[k] = fixed[p];
        k++;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/burst_guard_ctrl.sv
module burst_guard_ctrl
  import burst_guard_pkg::*;
#(
  parameter int N_WORDS = 16,
  localparam int IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wordValid,
  input  logic             rxValid,
  output logic             busy,
  output strobeT           strobe,
  output logic [IDX_W-1:0] txWrIdx,
  output logic [IDX_W-1:0] txWord,
  output logic [POS_W-1:0] txBitPos,
  output logic [IDX_W-1:0] rxWord,
  output logic [POS_W-1:0] rxBitPos,
  output logic [IDX_W-1:0] emitIdx
);

  localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(N_WORDS - 1);
  localparam logic [POS_W-1:0] LAST_POS  = POS_W'(CODE_W - 1);

  logic             sending;
  logic [IDX_W-1:0] loadCnt;
  logic [IDX_W-1:0] sendWord;
  logic [POS_W-1:0] sendBit;

  logic             copyPending;
  logic             emitActive;
  logic [IDX_W-1:0] rxWordQ;
  logic [POS_W-1:0] rxBitQ;
  logic [IDX_W-1:0] emitQ;
  logic             rxLast;

  // transmit sequencing: fill, then walk bit planes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sending  <= 1'b0;
      loadCnt  <= '0;
      sendWord <= '0;
      sendBit  <= '0;
    end else if (sending) begin
      if (sendWord == LAST_WORD) begin
        sendWord <= '0;
        if (sendBit == LAST_POS) begin
          sendBit <= '0;
          sending <= 1'b0;
        end else begin
          sendBit <= sendBit + POS_W'(1);
        end
      end else begin
        sendWord <= sendWord + IDX_W'(1);
      end
    end else if (wordValid) begin
      if (loadCnt == LAST_WORD) begin
        loadCnt  <= '0;
        sending  <= 1'b1;
        sendWord <= '0;
        sendBit  <= '0;
      end else begin
        loadCnt <= loadCnt + IDX_W'(1);
      end
    end
  end

  // receive sequencing: place bits, hand over, emit words
  assign rxLast = rxValid && (rxWordQ == LAST_WORD) && (rxBitQ == LAST_POS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxWordQ     <= '0;
      rxBitQ      <= '0;
      copyPending <= 1'b0;
      emitActive  <= 1'b0;
      emitQ       <= '0;
    end else begin
      copyPending <= rxLast;
      if (rxValid) begin
        if (rxWordQ == LAST_WORD) begin
          rxWordQ <= '0;
          rxBitQ  <= (rxBitQ == LAST_POS) ? '0 : rxBitQ + POS_W'(1);
        end else begin
          rxWordQ <= rxWordQ + IDX_W'(1);
        end
      end
      if (copyPending) begin
        emitActive <= 1'b1;
        emitQ      <= '0;
      end else if (emitActive) begin
        if (emitQ == LAST_WORD) emitActive <= 1'b0;
        else                    emitQ      <= emitQ + IDX_W'(1);
      end
    end
  end

  always_comb begin
    strobe.txWrite = wordValid && !sending;
    strobe.txSend  = sending;
    strobe.rxWrite = rxValid;
    strobe.rxCopy  = copyPending;
    strobe.rxEmit  = emitActive;
  end

  assign busy     = sending;
  assign txWrIdx  = loadCnt;
  assign txWord   = sendWord;
  assign txBitPos = sendBit;
  assign rxWord   = rxWordQ;
  assign rxBitPos = rxBitQ;
  assign emitIdx  = emitQ;

  // R2: the fill count is frozen while a block is on the line
  a_r2_load_frozen: assert property (@(posedge clk) disable iff (!rstN)
    sending |=> $stable(loadCnt));

  // R3: finishing a plane moves to the next plane, word 0
  a_r3_plane_order: assert property (@(posedge clk) disable iff (!rstN)
    (sending && (sendWord == LAST_WORD) && (sendBit != LAST_POS))
      |=> (sending && (sendWord == '0) && (sendBit == $past(sendBit) + POS_W'(1))));

  // R10: a hand-over never collides with emission of an earlier block
  a_r10_copy_clear: assert property (@(posedge clk) disable iff (!rstN)
    copyPending |-> !emitActive);

endmodule

// File: rtl/burst_guard_path.sv
module burst_guard_path
  import burst_guard_pkg::*;
#(
  parameter int N_WORDS = 16,
  localparam int IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strobe,
  input  dataT             wordData,
  input  logic [IDX_W-1:0] txWrIdx,
  input  logic [IDX_W-1:0] txWord,
  input  logic [POS_W-1:0] txBitPos,
  input  logic             rxBit,
  input  logic [IDX_W-1:0] rxWord,
  input  logic [POS_W-1:0] rxBitPos,
  input  logic [IDX_W-1:0] emitIdx,
  output logic             serBit,
  output logic             serValid,
  output dataT             outData,
  output logic             outCorrected,
  output logic             outDouble,
  output logic             outValid
);

  codeT   txView   [N_WORDS];
  codeT   holdView [N_WORDS];
  decodeT decoded;

  // one slot per word in each of the three stores
  for (genvar w = 0; w < N_WORDS; w++) begin : g_slot
    codeT txReg;
    codeT collReg;
    codeT holdReg;

    always_ff @(posedge clk) begin
      if (strobe.txWrite && (txWrIdx == IDX_W'(w))) txReg <= encodeWord(wordData);
      if (strobe.rxWrite && (rxWord == IDX_W'(w))) collReg[rxBitPos] <= rxBit;
      if (strobe.rxCopy) holdReg <= collReg;
    end

    assign txView[w]   = txReg;
    assign holdView[w] = holdReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serBit   <= 1'b0;
      serValid <= 1'b0;
    end else begin
      serValid <= strobe.txSend;
      if (strobe.txSend) serBit <= txView[txWord][txBitPos];
    end
  end

  assign decoded = decodeWord(holdView[emitIdx]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      outData      <= '0;
      outCorrected <= 1'b0;
      outDouble    <= 1'b0;
    end else begin
      outValid <= strobe.rxEmit;
      if (strobe.rxEmit) begin
        outData      <= decoded.data;
        outCorrected <= decoded.corrected;
        outDouble    <= decoded.dbl;
      end
    end
  end

  // R7/R8: a word is never both repaired and declared unrepairable
  a_r7_flag_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !(outCorrected && outDouble));

endmodule

// File: rtl/burst_guard_link.sv
module burst_guard_link
  import burst_guard_pkg::*;
#(
  parameter int N_WORDS = 16,
  localparam int IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [DATA_W-1:0] wordData,
  output logic              busy,
  output logic              serBit,
  output logic              serValid,
  input  logic              rxValid,
  input  logic              rxBit,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outCorrected,
  output logic              outDouble
);

  strobeT           strobe;
  logic [IDX_W-1:0] txWrIdx;
  logic [IDX_W-1:0] txWord;
  logic [POS_W-1:0] txBitPos;
  logic [IDX_W-1:0] rxWord;
  logic [POS_W-1:0] rxBitPos;
  logic [IDX_W-1:0] emitIdx;

  burst_guard_ctrl #(.N_WORDS(N_WORDS)) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wordValid(wordValid),
    .rxValid  (rxValid),
    .busy     (busy),
    .strobe   (strobe),
    .txWrIdx  (txWrIdx),
    .txWord   (txWord),
    .txBitPos (txBitPos),
    .rxWord   (rxWord),
    .rxBitPos (rxBitPos),
    .emitIdx  (emitIdx)
  );

  burst_guard_path #(.N_WORDS(N_WORDS)) path (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wordData    (wordData),
    .txWrIdx     (txWrIdx),
    .txWord      (txWord),
    .txBitPos    (txBitPos),
    .rxBit       (rxBit),
    .rxWord      (rxWord),
    .rxBitPos    (rxBitPos),
    .emitIdx     (emitIdx),
    .serBit      (serBit),
    .serValid    (serValid),
    .outData     (outData),
    .outCorrected(outCorrected),
    .outDouble   (outDouble),
    .outValid    (outValid)
  );

  // R3: the line starts the cycle after busy rises
  a_r3_first_bit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> serValid);

  // R3: busy drops while the final line bit is presented
  a_r3_last_bit: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> serValid);

  // R5: decoded output starts two edges after the hand-over strobe
  a_r5_emit_after_copy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(strobe.rxCopy, 2));

endmodule

// File: tb/burst_guard_link_test.sv
module burst_guard_link_test;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 16;
  localparam int CW = 13;
  localparam int LINE = CW * NW;

  typedef logic [CW-1:0] cwT;
  typedef cwT cwBlkT [NW];
  typedef logic [7:0] datBlkT [NW];
  typedef struct {
    logic [7:0] data;
    logic       corr;
    logic       dbl;
    string      req;
  } expT;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wordValid = 1'b0;
  logic [7:0] wordData = '0;
  logic       busy, serBit, serValid;
  logic       rxValid, rxBit;
  logic       outValid, outCorrected, outDouble;
  logic [7:0] outData;

  logic            loopMode = 1'b0;
  logic            lbValid = 1'b0, lbBit = 1'b0;
  logic            dValid = 1'b0, dBit = 1'b0;
  logic [LINE-1:0] flipMask = '0;
  cwT              expCode [NW];
  int              lineCnt = 0;
  int              doneLen = 0;
  expT             sbQ [$];
  int              checks = 0;
  int              failures = 0;

  assign rxValid = loopMode ? lbValid : dValid;
  assign rxBit   = loopMode ? lbBit   : dBit;

  always #(CLK_PERIOD / 2) clk = ~clk;

  burst_guard_link #(.N_WORDS(NW)) uut (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordData(wordData),
    .busy(busy), .serBit(serBit), .serValid(serValid),
    .rxValid(rxValid), .rxBit(rxBit),
    .outValid(outValid), .outData(outData),
    .outCorrected(outCorrected), .outDouble(outDouble)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // codeword built straight from the R1 layout
  function automatic cwT benchEncode(input logic [7:0] d);
    int dpos [8];
    cwT c;
    dpos = '{3, 5, 6, 7, 9, 10, 11, 12};
    c = '0;
    for (int i = 0; i < 8; i++) c[dpos[i]] = d[i];
    c[1] = c[3] ^ c[5] ^ c[7] ^ c[9] ^ c[11];
    c[2] = c[3] ^ c[6] ^ c[7] ^ c[10] ^ c[11];
    c[4] = c[5] ^ c[6] ^ c[7] ^ c[12];
    c[8] = c[9] ^ c[10] ^ c[11] ^ c[12];
    c[0] = ^c[12:1];
    return c;
  endfunction

  // loopback line: checks the stream, injects flips, feeds the receiver
  always @(negedge clk) begin
    if (loopMode) begin
      lbValid <= serValid;
      if (serValid) begin
        check(serBit === expCode[lineCnt % NW][lineCnt / NW], "R1",
              $sformatf("line bit %0d", lineCnt), serBit,
              expCode[lineCnt % NW][lineCnt / NW]);
        lbBit   <= serBit ^ flipMask[lineCnt];
        lineCnt <= lineCnt + 1;
        if (!busy) doneLen <= lineCnt + 1;
      end else if (!busy) begin
        lineCnt <= 0;
      end
    end else begin
      lbValid <= 1'b0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    expT e;
    if (rstN && outValid) begin
      if (sbQ.size() == 0) begin
        check(1'b0, "R5", "output with nothing expected", 1, 0);
      end else begin
        e = sbQ.pop_front();
        if (e.dbl) begin
          check(outDouble && !outCorrected, e.req, "flags {corr,dbl}",
                {outCorrected, outDouble}, 1);
        end else begin
          check(outData == e.data, e.req, "data", outData, e.data);
          check(outCorrected == e.corr && !outDouble, e.req, "flags {corr,dbl}",
                {outCorrected, outDouble}, {e.corr, 1'b0});
        end
      end
    end
  end

  task automatic pushExp(input logic [7:0] d, input int flips, input string req);
    expT e;
    e.data = d;
    e.corr = (flips == 1);
    e.dbl  = (flips >= 2);
    e.req  = req;
    sbQ.push_back(e);
  endtask

  task automatic loadBlock(input datBlkT d, input logic [LINE-1:0] mask,
                           input string req, input string reqClean);
    flipMask = mask;
    for (int w = 0; w < NW; w++) begin
      int n;
      n = 0;
      for (int b = 0; b < CW; b++) n += mask[b * NW + w];
      pushExp(d[w], n, (n == 0) ? reqClean : req);
      expCode[w] = benchEncode(d[w]);
    end
    for (int w = 0; w < NW; w++) begin
      wordValid = 1'b1;
      wordData  = d[w];
      @(negedge clk);
    end
    check(busy == 1'b1, "R2", "busy after last load", busy, 1);
    check(serValid == 1'b0, "R3", "serValid one cycle before start", serValid, 0);
    // R2: junk offered while busy must not be taken
    wordData = 8'hA5;
    @(negedge clk);
    check(serValid == 1'b1, "R3", "serValid after busy rise", serValid, 1);
    repeat (20) @(negedge clk);
    wordValid = 1'b0;
    while (busy) @(negedge clk);
    check(serValid == 1'b1, "R3", "last bit when busy falls", serValid, 1);
    @(negedge clk);
    check(doneLen == LINE, "R3", "line bits per block", doneLen, LINE);
    repeat (NW + 8) @(negedge clk);
    check(sbQ.size() == 0, "R5", "words left after block", sbQ.size(), 0);
  endtask

  task automatic driveRx(input cwBlkT cw, input int gapEvery);
    for (int b = 0; b < CW; b++) begin
      for (int w = 0; w < NW; w++) begin
        dValid = 1'b1;
        dBit   = cw[w][b];
        @(negedge clk);
        if (gapEvery > 0 && ((b * NW + w) % gapEvery == 0)) begin
          dValid = 1'b0;
          dBit   = ~dBit;
          @(negedge clk);
        end
      end
    end
  endtask

  initial begin
    datBlkT          d;
    cwBlkT           cw;
    cwBlkT           cw2;
    logic [LINE-1:0] m;

    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R11", "busy in reset", busy, 0);
    check(serValid == 1'b0, "R11", "serValid in reset", serValid, 0);
    check(outValid == 1'b0, "R11", "outValid in reset", outValid, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    loopMode = 1'b1;
    // clean block
    for (int w = 0; w < NW; w++) d[w] = 8'(w * 17 + 3);
    loadBlock(d, '0, "R6", "R6");
    // burst of NW line bits in the middle (R9); also proves R2 junk was dropped
    for (int w = 0; w < NW; w++) d[w] = ~8'(w * 29);
    m = '0;
    for (int i = 0; i < NW; i++) m[37 + i] = 1'b1;
    loadBlock(d, m, "R9", "R9");
    // burst over plane 0: every overall-parity bit hit (R7)
    for (int w = 0; w < NW; w++) d[w] = 8'(w * 53 + 200);
    m = '0;
    for (int i = 0; i < NW; i++) m[i] = 1'b1;
    loadBlock(d, m, "R7", "R6");
    // two hits on word 5 (R8)
    for (int w = 0; w < NW; w++) d[w] = 8'(255 - w * 11);
    m = '0;
    m[5] = 1'b1;
    m[5 + 4 * NW] = 1'b1;
    loadBlock(d, m, "R8", "R6");

    loopMode = 1'b0;
    repeat (4) @(negedge clk);

    // direct block with gaps: singles at every position, two doubles (R4, R7, R8)
    for (int w = 0; w < NW; w++) begin
      d[w]  = 8'(w * 37 + 9);
      cw[w] = benchEncode(d[w]);
      if (w < CW) begin
        cw[w][w] = ~cw[w][w];
        pushExp(d[w], 1, "R7");
      end else if (w == CW) begin
        pushExp(d[w], 0, "R4");
      end else if (w == CW + 1) begin
        cw[w][2] = ~cw[w][2];
        cw[w][9] = ~cw[w][9];
        pushExp(d[w], 2, "R8");
      end else begin
        cw[w][0]  = ~cw[w][0];
        cw[w][12] = ~cw[w][12];
        pushExp(d[w], 2, "R8");
      end
    end
    driveRx(cw, 7);
    dValid = 1'b0;
    check(outValid == 1'b0, "R5", "outValid one edge after last bit", outValid, 0);
    @(negedge clk);
    check(outValid == 1'b0, "R5", "outValid two edges after last bit", outValid, 0);
    @(negedge clk);
    check(outValid == 1'b1, "R5", "outValid start", outValid, 1);
    repeat (NW + 4) @(negedge clk);
    check(sbQ.size() == 0, "R5", "words left after direct block", sbQ.size(), 0);

    // two blocks with no idle cycle between them (R10)
    for (int w = 0; w < NW; w++) begin
      d[w]  = 8'(w * 71 + 1);
      cw[w] = benchEncode(d[w]);
      cw[w][(w * 5) % CW] = ~cw[w][(w * 5) % CW];
      pushExp(d[w], 1, "R10");
    end
    for (int w = 0; w < NW; w++) begin
      d[w]   = 8'(w * 13 + 100);
      cw2[w] = benchEncode(d[w]);
      if (w[0]) cw2[w][(w * 3) % CW] = ~cw2[w][(w * 3) % CW];
      pushExp(d[w], w[0] ? 1 : 0, "R10");
    end
    driveRx(cw, 0);
    driveRx(cw2, 0);
    dValid = 1'b0;
    repeat (NW + 6) @(negedge clk);
    check(sbQ.size() == 0, "R10", "words left after back-to-back", sbQ.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R5", "watchdog expired", 100000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule